// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that software feeds over a simple write port. A 16-bit up-counter advances on ticks from a free-running prescaler, where one of eight power-of-two divisions picks the tick rate. When the counter passes 0xFFFF while the timer is enabled, it wraps to zero. The block then raises a one-cycle reset request and latches a sticky overflow flag.

There are two 32-bit write targets: the counter and the control/status word. Each has its own key in the upper bits, and a write with the wrong key does nothing. Every accepted write sets a busy flag, and that flag stays set for two prescaler ticks. While it is set, further writes are refused. Software therefore polls the flag between steps, for example between disabling the timer and reloading the counter.

To get a timeout of N ticks, software loads 65536 − N into the counter. To force an immediate reset, software loads 0xFFFF, selects division 1 and enables the timer.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the counter reads 0, the status word reads 0x00 and the reset request output is low.
- R2: A status-word write (select = 1) takes effect only if bits [31:8] equal 0xA5A5A5. It loads the enable bit from bit 7 and the division index from bits [2:0]. A write with any other key changes nothing.
- R3: A counter write (select = 0) takes effect only if bits [31:16] equal 0x5A5A. It loads bits [15:0] into the counter. A write with any other key changes nothing.
- R4: The counter steps by exactly 1 on each prescaler tick, and only while the enable bit (status bit 7) is set. The prescaler is a 12-bit count of cycles since reset. A tick occurs in a cycle whose count has its low k bits all ones, where k is 0, 2, 4, 5, 6, 7, 10 or 12 for division index 0 to 7. This gives divisions of 1, 4, 16, 32, 64, 128, 1024 and 4096.
- R5: When an enabled counter at 0xFFFF takes a tick, it wraps to 0. The overflow flag (status bit 4) is set, and the reset request is high for exactly one cycle, in the same cycle the flag first reads 1.
- R6: The overflow flag stays set until an accepted status-word write with bit 4 equal to 0. An accepted write with bit 4 equal to 1 leaves it set.
- R7: Status bit 5 (busy) reads 1 from the cycle after an accepted write until two prescaler ticks have passed. Writes made while it reads 1 are ignored.
- R8: With the counter at 0xFFFF and division index 0, an accepted write that sets the enable bit is followed, one cycle after the enable appears, by the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_sel_i | input | 1 | Write target: 1 = status word, 0 = counter |
| wr_data_i | input | 32 | Write data with key in upper bits |
| count_o | output | 16 | Current counter value |
| csr_o | output | 8 | Status word: bit 7 enable, bit 5 busy, bit 4 overflow, bits [2:0] division index |
| rst_req_o | output | 1 | One-cycle reset request on overflow |

## Verification
The assertions check, on every cycle, the following properties:
- The reset request is a single-cycle pulse that coincides with the overflow flag.
- The overflow flag cannot drop without a keyed status write.
- Bad keys and busy periods leave the control fields untouched.
- The counter only ever moves by +1 unless it is loaded.

The exact tick spacing for each division, the two-tick length of the busy window, the timing of the forced reset, and the values loaded by accepted writes can only be shown by the bench. It does this with a cycle-by-cycle model under directed sequences and a long stretch of random writes with mixed keys.

// File: rtl/kgw_pkg.sv
package kgw_pkg;
  localparam int CNT_W      = 16;
  localparam int PRE_W      = 12;
  localparam int DIV_SEL_W  = 3;
  localparam int BUSY_TICKS = 2;
  localparam int BUSY_W     = $clog2(BUSY_TICKS + 1);

  localparam logic [23:0] CSR_KEY = 24'hA5A5A5;
  localparam logic [15:0] CNT_KEY = 16'h5A5A;

  localparam int EN_BIT   = 7;
  localparam int BUSY_BIT = 5;
  localparam int OVF_BIT  = 4;

  function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    case (sel)
      3'd0:    m = PRE_W'(12'h000);
      3'd1:    m = PRE_W'(12'h003);
      3'd2:    m = PRE_W'(12'h00F);
      3'd3:    m = PRE_W'(12'h01F);
      3'd4:    m = PRE_W'(12'h03F);
      3'd5:    m = PRE_W'(12'h07F);
      3'd6:    m = PRE_W'(12'h3FF);
      default: m = PRE_W'(12'hFFF);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/kgw_prescaler.sv
module kgw_prescaler
  import kgw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 tick_o
);
  logic [PRE_W-1:0] presc_q, presc_d, mask;

  always_comb begin
    mask    = div_mask(div_sel_i);
    presc_d = presc_q + PRE_W'(1);
    tick_o  = ((presc_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) presc_q <= '0;
    else         presc_q <= presc_d;
  end
endmodule

// File: rtl/kgw_wr_gate.sv
module kgw_wr_gate
  import kgw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        tick_i,
  output logic        ld_csr_o,
  output logic        ld_cnt_o,
  output logic        busy_o
);
  logic [BUSY_W-1:0] busy_q, busy_d;
  logic              busy_we;
  logic              key_csr, key_cnt, idle;

  always_comb begin
    key_csr  = (wr_data_i[31:8]  == CSR_KEY);
    key_cnt  = (wr_data_i[31:16] == CNT_KEY);
    idle     = (busy_q == '0);
    ld_csr_o = wr_en_i &  wr_sel_i & key_csr & idle;
    ld_cnt_o = wr_en_i & ~wr_sel_i & key_cnt & idle;
    busy_o   = ~idle;
    busy_we  = ld_csr_o | ld_cnt_o | (tick_i & ~idle);
    busy_d   = (ld_csr_o | ld_cnt_o) ? BUSY_W'(BUSY_TICKS) : busy_q - BUSY_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= '0;
    else if (busy_we) busy_q <= busy_d;
  end
endmodule

// File: rtl/kgw_counter.sv
module kgw_counter
  import kgw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, cnt_we;

  always_comb begin
    step    = run_i & tick_i & ~ld_i;
    wrap_o  = step & (&cnt_q);
    cnt_we  = ld_i | step;
    cnt_d   = ld_i ? ld_val_i : cnt_q + CNT_W'(1);
    count_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import kgw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic [15:0] count_o,
  output logic [7:0]  csr_o,
  output logic        rst_req_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic                 en_q, en_d, ovf_q, ovf_d, req_q, req_d;
  logic [DIV_SEL_W-1:0] div_q, div_d;
  logic                 tick, ld_csr, ld_cnt, busy, wrap;
  logic [CNT_W-1:0]     cnt;

  kgw_prescaler u_presc (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .div_sel_i(div_q), .tick_o(tick)
  );

  kgw_wr_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .tick_i(tick), .ld_csr_o(ld_csr), .ld_cnt_o(ld_cnt),
    .busy_o(busy)
  );

  kgw_counter u_cnt (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .run_i(en_q), .tick_i(tick),
    .ld_i(ld_cnt), .ld_val_i(wr_data_i[CNT_W-1:0]), .count_o(cnt), .wrap_o(wrap)
  );

  always_comb begin
    en_d  = ld_csr ? wr_data_i[EN_BIT] : en_q;
    div_d = ld_csr ? wr_data_i[DIV_SEL_W-1:0] : div_q;
    ovf_d = wrap | (ld_csr ? (ovf_q & wr_data_i[OVF_BIT]) : ovf_q);
    req_d = wrap;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
      ovf_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      div_q <= div_d;
      ovf_q <= ovf_d;
      req_q <= req_d;
    end
  end

  assign count_o   = cnt;
  assign csr_o     = {en_q, 1'b0, busy, ovf_q, 1'b0, div_q};
  assign rst_req_o = req_q;
endmodule

// File: rtl/keyguard_wdt_chk.sv
module keyguard_wdt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic [15:0] count_o,
  input logic [7:0]  csr_o,
  input logic        rst_req_o
);
  logic csr_ok, cnt_ok, csr_bad, cnt_bad;
  assign csr_ok  = wr_en_i &  wr_sel_i & (wr_data_i[31:8]  == 24'hA5A5A5) & ~csr_o[5];
  assign cnt_ok  = wr_en_i & ~wr_sel_i & (wr_data_i[31:16] == 16'h5A5A)   & ~csr_o[5];
  assign csr_bad = wr_en_i &  wr_sel_i & (wr_data_i[31:8]  != 24'hA5A5A5);
  assign cnt_bad = wr_en_i & ~wr_sel_i & (wr_data_i[31:16] != 16'h5A5A);

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R5
  AST_REQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> csr_o[4]); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[4] && !csr_ok) |=> csr_o[4]); // R6
  AST_BADKEY_CSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_bad |=> $stable({csr_o[7], csr_o[2:0]})); // R2
  AST_BADKEY_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_bad && !csr_o[7]) |=> $stable(count_o)); // R3
  AST_BUSY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[5] |=> $stable({csr_o[7], csr_o[2:0]})); // R7
  AST_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_o[7] && !cnt_ok) |=> $stable(count_o)); // R4
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_ok) && (count_o != $past(count_o))) |-> (count_o == $past(count_o) + 16'd1)); // R4
endmodule

bind keyguard_wdt keyguard_wdt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_sync_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .count_o(count_o), .csr_o(csr_o), .rst_req_o(rst_req_o)
);

// File: tb/keyguard_wdt_tb.sv
module keyguard_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [15:0] count_o;
  logic [7:0]  csr_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  keyguard_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .count_o(count_o), .csr_o(csr_o), .rst_req_o(rst_req_o)
  );

  // reference model state
  logic        m_s1, m_s2, m_en, m_ovf, m_req;
  logic [2:0]  m_div;
  logic [15:0] m_cnt;
  logic [11:0] m_pc;
  int          m_busy;

  function automatic logic [11:0] f_mask(input logic [2:0] s);
    int k;
    case (s)
      3'd0: k = 0;  3'd1: k = 2;  3'd2: k = 4;  3'd3: k = 5;
      3'd4: k = 6;  3'd5: k = 7;  3'd6: k = 10; default: k = 12;
    endcase
    return 12'((1 << k) - 1);
  endfunction

  function automatic logic f_key(input logic sel, input logic [31:0] d);
    return sel ? (d[31:8] == 24'hA5A5A5) : (d[31:16] == 16'h5A5A);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_en = 0; m_ovf = 0; m_req = 0;
      m_div = 0; m_cnt = 0; m_pc = 0; m_busy = 0;
    end else begin
      if (!m_s2) begin
        m_en = 0; m_ovf = 0; m_req = 0; m_div = 0; m_cnt = 0; m_pc = 0; m_busy = 0;
      end else begin
        logic tk, acc, wr, ldc;
        tk  = ((m_pc & f_mask(m_div)) == f_mask(m_div));
        acc = wr_en && (m_busy == 0) && f_key(wr_sel, wr_data);
        ldc = acc && !wr_sel;
        wr  = m_en && tk && !ldc && (m_cnt == 16'hFFFF);
        m_req = wr;
        if (acc && wr_sel) m_ovf = m_ovf & wr_data[4];
        if (wr) m_ovf = 1'b1;
        if (ldc) m_cnt = wr_data[15:0];
        else if (m_en && tk) m_cnt = m_cnt + 16'd1;
        if (acc) m_busy = 2;
        else if (tk && m_busy != 0) m_busy = m_busy - 1;
        if (acc && wr_sel) begin m_en = wr_data[7]; m_div = wr_data[2:0]; end
        m_pc = m_pc + 12'd1;
      end
      m_s2 = m_s1; m_s1 = 1'b1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R4 count", 32'(count_o), 32'(m_cnt));
      check("R2 control", {28'd0, csr_o[7], csr_o[2:0]}, {28'd0, m_en, m_div});
      check("R6 overflow", 32'(csr_o[4]), 32'(m_ovf));
      check("R7 busy", 32'(csr_o[5]), 32'(m_busy != 0));
      check("R5 request", 32'(rst_req_o), 32'(m_req));
    end
  end

  task automatic do_write(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (csr_o[5]) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] pre;
    bit seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(count_o), 32'd0);
    check("R1 csr", 32'(csr_o), 32'd0);
    check("R1 request", 32'(rst_req_o), 32'd0);
    cmp_on = 1'b1;

    // R2 wrong key ignored, right key accepted
    do_write(1'b1, {24'h123456, 8'h80});
    check("R2 badkey enable", 32'(csr_o[7]), 32'd0);
    do_write(1'b1, {24'hA5A5A5, 8'h81});
    check("R2 enable", 32'(csr_o[7]), 32'd1);
    check("R7 busy set", 32'(csr_o[5]), 32'd1);
    // R7 write during busy is ignored
    do_write(1'b1, {24'hA5A5A5, 8'h00});
    check("R7 busy write ignored", 32'(csr_o[7]), 32'd1);
    wait_idle();
    do_write(1'b1, {24'hA5A5A5, 8'h00});
    wait_idle();

    // R3 counter key
    pre = count_o;
    do_write(1'b0, {16'h1234, 16'hFFF0});
    check("R3 badkey count", 32'(count_o), 32'(pre));
    wait_idle();
    do_write(1'b0, {16'h5A5A, 16'hFFF0});
    check("R3 load", 32'(count_o), 32'h0000FFF0);
    wait_idle();

    // R5 overflow with division 1
    do_write(1'b1, {24'hA5A5A5, 8'h80});
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (rst_req_o) seen = 1; else @(negedge clk);
    end
    check("R5 request seen", 32'(seen), 32'd1);
    check("R5 flag", 32'(csr_o[4]), 32'd1);
    check("R5 wrap to zero", 32'(count_o), 32'd0);
    @(negedge clk);
    check("R5 single cycle", 32'(rst_req_o), 32'd0);
    wait_idle();

    // R6 sticky flag
    do_write(1'b1, {24'hA5A5A5, 8'h10});
    check("R6 keep", 32'(csr_o[4]), 32'd1);
    wait_idle();
    do_write(1'b1, {24'hA5A5A5, 8'h00});
    check("R6 clear", 32'(csr_o[4]), 32'd0);
    wait_idle();

    // R4 tick spacing at division 16
    do_write(1'b0, {16'h5A5A, 16'h0000});
    wait_idle();
    do_write(1'b1, {24'hA5A5A5, 8'h82});
    pre = count_o;
    repeat (64) @(negedge clk);
    check("R4 div16 ticks", 32'(count_o - pre), 32'd4);
    do_write(1'b1, {24'hA5A5A5, 8'h02});
    wait_idle();
    pre = count_o;
    repeat (40) @(negedge clk);
    check("R4 halted", 32'(count_o), 32'(pre));

    // R8 forced reset
    do_write(1'b1, {24'hA5A5A5, 8'h00});
    wait_idle();
    do_write(1'b0, {16'h5A5A, 16'hFFFF});
    wait_idle();
    do_write(1'b1, {24'hA5A5A5, 8'h80});
    check("R8 enable seen", 32'(csr_o[7]), 32'd1);
    @(negedge clk);
    check("R8 request", 32'(rst_req_o), 32'd1);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      logic [2:0]  dv;
      logic        ok;
      r  = $urandom;
      ok = (r[7:5] != 3'd0);
      dv = r[10] ? 3'd0 : r[13:11];
      wr_en  = (r[1:0] == 2'd0);
      wr_sel = r[4];
      if (r[4])
        wr_data = {ok ? 24'hA5A5A5 : 24'hA5A5A4, r[8] | r[15], 2'b00, r[9], 1'b0, dv};
      else
        wr_data = {ok ? 16'h5A5A : 16'h5A5B, r[20] ? r[31:16] : {12'hFFF, r[19:16]}};
      @(negedge clk);
    end
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule